// File: doc/BRIEF.md
# Three-Digit Decimal Card Processor

This block is a small stored-program processor that works in decimal. Memory holds one hundred signed three-digit words. One signed accumulator with a four-digit magnitude does the arithmetic. Every instruction word carries a one-digit opcode and a two-digit cell address. Input cards arrive through a valid/ready handshake and are written straight into a memory cell. Output cards go out through a second valid/ready handshake and are taken straight from a memory cell.

Beyond load, store and add/subtract, the machine has three less usual operations. A decimal shift moves the accumulator left and then right, and the two digit counts come from the two address digits. A sign-test branch is taken only when the accumulator is negative. The jump instruction also leaves a return instruction in the top cell, so a subroutine returns when execution reaches that cell. A halt instruction first moves the program counter to its address and then stops the machine.

While reset is high, a loader port writes the program and data into memory. Reset clears the processor state but keeps the memory contents. When reset is released, execution begins at the cell given by `RESET_PC`, which defaults to 10. The halt state is left only through reset.

Top module: `dcpu_card_cpu`

## Requirements
- R1: While reset is high, `pc` equals RESET_PC (10), the accumulator is +0000, `halted`, `in_ready` and `out_valid` are 0, and each loader write with `ld_we` high stores its word into the addressed cell.
- R2: The hundreds digit of the instruction magnitude is the opcode (0 input, 1 clear-and-add, 2 add, 3 sign test, 4 shift, 5 output, 6 store, 7 subtract, 8 jump, 9 halt). The low two digits are the address. The sign of the instruction word has no effect.
- R3: Clear-and-add loads the signed cell value into the accumulator. Add and subtract combine the cell value with the accumulator as signed numbers. Only the result magnitude modulo 10000 is kept, and a zero magnitude is always positive.
- R4: Store writes the accumulator sign and the low three digits of its magnitude into the cell, and leaves the accumulator unchanged.
- R5: During an input instruction `in_ready` is 1 and the processor waits. The card accepted when `in_valid` is also 1 is written into the addressed cell.
- R6: During an output instruction `out_valid` is 1 and `out_neg`/`out_mag` show the addressed cell. The data and `pc` stay stable until `out_ready` is 1.
- R7: The sign-test instruction sets `pc` to the address when the accumulator is negative. Otherwise `pc` moves to the next cell, and cell 99 is followed by cell 00.
- R8: The shift instruction with address digits x (tens) and y (units) multiplies the accumulator magnitude by 10^x modulo 10000, then divides it by 10^y and truncates. The sign is kept unless the result is zero.
- R9: The jump instruction writes +(800 + next cell) into cell 99, where the next cell after 99 is 00, and sets `pc` to the address.
- R10: The halt instruction sets `pc` to its address and raises `halted`. After that, `pc` and memory stay unchanged and no handshake is offered until reset.
- R11: Cell 00 always reads +001. Writes to it from the loader, from store or from input have no effect.
- R12: Every instruction other than input and output takes exactly two clock cycles: one to fetch and one to execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; enables the loader |
| ld_we | input | 1 | Loader write strobe, honoured only in reset |
| ld_addr | input | 7 | Loader cell address |
| ld_neg | input | 1 | Loader word sign (1 = negative) |
| ld_mag | input | 10 | Loader word magnitude, 0..999 |
| in_valid | input | 1 | Input card present |
| in_ready | output | 1 | Processor takes an input card |
| in_neg | input | 1 | Input card sign |
| in_mag | input | 10 | Input card magnitude |
| out_valid | output | 1 | Output card present |
| out_ready | input | 1 | Output card taken |
| out_neg | output | 1 | Output card sign |
| out_mag | output | 10 | Output card magnitude |
| pc | output | 7 | Program counter |
| acc_neg | output | 1 | Accumulator sign |
| acc_mag | output | 14 | Accumulator magnitude, 0..9999 |
| halted | output | 1 | Halt reached |

## Verification
A fault in the decode or in the accumulator shows up at `acc_neg`/`acc_mag` one cycle after the execute edge, so short three-instruction programs swept over many operands expose it at once. A wrong link word or a wrong write into cell 00 stays hidden inside memory until a later output instruction sends that cell out on a card. The tests therefore end with those cells being sent out. A wrong program counter shows up either as a wrong final `pc` when the program halts, or as a halt that never happens.

// File: rtl/dcpu_pkg.sv
package dcpu_pkg;
    localparam int CELLS     = 100;
    localparam int AW        = 7;
    localparam int CMAG_W    = 10;
    localparam int AMAG_W    = 14;
    localparam int ACC_MOD   = 10000;
    localparam int CELL_MOD  = 1000;
    localparam int LINK_CELL = CELLS - 1;
    localparam int LINK_BASE = 800;

    typedef struct packed {
        logic              neg;
        logic [CMAG_W-1:0] mag;
    } cell_t;

    typedef struct packed {
        logic              neg;
        logic [AMAG_W-1:0] mag;
    } acc_t;

    typedef enum logic [3:0] {
        OP_INP = 4'd0, OP_CLA = 4'd1, OP_ADD = 4'd2, OP_TAC = 4'd3,
        OP_SFT = 4'd4, OP_OUT = 4'd5, OP_STO = 4'd6, OP_SUB = 4'd7,
        OP_JMP = 4'd8, OP_HRS = 4'd9
    } op_e;

    typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_e;

    localparam cell_t CELL_ONE = '{neg: 1'b0, mag: CMAG_W'(1)};

    function automatic int pow10(input int n);
        case (n)
            0:       return 1;
            1:       return 10;
            2:       return 100;
            3:       return 1000;
            default: return 10000;
        endcase
    endfunction

    function automatic acc_t acc_from_int(input int r);
        acc_t a;
        int   m;
        m     = (r < 0) ? -r : r;
        m     = m % ACC_MOD;
        a.mag = AMAG_W'(m);
        a.neg = (r < 0) && (m != 0);
        return a;
    endfunction
endpackage

// File: rtl/dcpu_mem.sv
module dcpu_mem
    import dcpu_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cell_t         wdata,
    input  logic [AW-1:0] iaddr,
    output cell_t         idata,
    input  logic [AW-1:0] daddr,
    output cell_t         ddata
);
    cell_t             cells [CELLS];
    logic [CMAG_W-1:0] wmag;
    logic              wok;

    always_comb begin
        wmag = CMAG_W'(wdata.mag % CMAG_W'(CELL_MOD));
        wok  = we && (waddr != '0) && (int'(waddr) < CELLS);
    end

    always_ff @(posedge clk) begin
        if (wok) cells[waddr] <= '{neg: wdata.neg && (wmag != '0), mag: wmag};
    end

    always_comb begin
        if (iaddr == '0)              idata = CELL_ONE;
        else if (int'(iaddr) < CELLS) idata = cells[iaddr];
        else                          idata = '0;
    end

    always_comb begin
        if (daddr == '0)              ddata = CELL_ONE;
        else if (int'(daddr) < CELLS) ddata = cells[daddr];
        else                          ddata = '0;
    end
endmodule

// File: rtl/dcpu_alu.sv
module dcpu_alu
    import dcpu_pkg::*;
(
    input  op_e        op,
    input  acc_t       acc,
    input  cell_t      opnd,
    input  logic [3:0] sh_left,
    input  logic [3:0] sh_right,
    output acc_t       acc_nx
);
    int a_i, b_i, lm_i;

    always_comb begin
        a_i  = acc.neg ? -int'(acc.mag) : int'(acc.mag);
        b_i  = opnd.neg ? -int'(opnd.mag) : int'(opnd.mag);
        lm_i = 0;
        unique case (op)
            OP_CLA: acc_nx = acc_from_int(b_i);
            OP_ADD: acc_nx = acc_from_int(a_i + b_i);
            OP_SUB: acc_nx = acc_from_int(a_i - b_i);
            OP_SFT: begin
                lm_i = (sh_left >= 4'd4) ? 0
                     : (int'(acc.mag) * pow10(int'(sh_left))) % ACC_MOD;
                lm_i = (sh_right >= 4'd4) ? 0 : lm_i / pow10(int'(sh_right));
                acc_nx.mag = AMAG_W'(lm_i);
                acc_nx.neg = acc.neg && (lm_i != 0);
            end
            default: acc_nx = acc;
        endcase
    end
endmodule

// File: rtl/dcpu_card_cpu.sv
module dcpu_card_cpu
    import dcpu_pkg::*;
#(
    parameter int RESET_PC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [AW-1:0]     ld_addr,
    input  logic              ld_neg,
    input  logic [CMAG_W-1:0] ld_mag,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_neg,
    input  logic [CMAG_W-1:0] in_mag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_neg,
    output logic [CMAG_W-1:0] out_mag,
    output logic [AW-1:0]     pc,
    output logic              acc_neg,
    output logic [AMAG_W-1:0] acc_mag,
    output logic              halted
);
    state_e        state;
    cell_t         ir, idata, ddata, ex_wdata, m_wdata;
    acc_t          acc, acc_nx;
    op_e           op;
    logic [AW-1:0] ir_addr, pc_inc, ex_waddr, m_waddr;
    logic          ex_we, m_we, in_exec;
    logic [3:0]    sh_left, sh_right;

    always_comb begin
        op       = op_e'(4'(ir.mag / CMAG_W'(100)));
        ir_addr  = AW'(ir.mag % CMAG_W'(100));
        sh_left  = 4'(ir_addr / AW'(10));
        sh_right = 4'(ir_addr % AW'(10));
        pc_inc   = (pc == AW'(CELLS - 1)) ? '0 : pc + 1'b1;
        in_exec  = (state == ST_EXEC);
    end

    always_comb begin
        ex_we    = 1'b0;
        ex_waddr = ir_addr;
        ex_wdata = '0;
        if (in_exec) begin
            unique case (op)
                OP_INP: begin
                    ex_we    = in_valid;
                    ex_wdata = '{neg: in_neg, mag: in_mag};
                end
                OP_STO: begin
                    ex_we    = 1'b1;
                    ex_wdata = '{neg: acc.neg, mag: CMAG_W'(acc.mag % AMAG_W'(CELL_MOD))};
                end
                OP_JMP: begin
                    ex_we    = 1'b1;
                    ex_waddr = AW'(LINK_CELL);
                    ex_wdata = '{neg: 1'b0, mag: CMAG_W'(LINK_BASE) + CMAG_W'(pc_inc)};
                end
                default: ex_we = 1'b0;
            endcase
        end
        m_we    = rst ? ld_we : ex_we;
        m_waddr = rst ? ld_addr : ex_waddr;
        m_wdata = rst ? '{neg: ld_neg, mag: ld_mag} : ex_wdata;
    end

    dcpu_mem mem_i (
        .clk   (clk),
        .we    (m_we),
        .waddr (m_waddr),
        .wdata (m_wdata),
        .iaddr (pc),
        .idata (idata),
        .daddr (ir_addr),
        .ddata (ddata)
    );

    dcpu_alu alu_i (
        .op       (op),
        .acc      (acc),
        .opnd     (ddata),
        .sh_left  (sh_left),
        .sh_right (sh_right),
        .acc_nx   (acc_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            pc    <= AW'(RESET_PC);
            acc   <= '0;
            ir    <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= idata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    unique case (op)
                        OP_INP: if (in_valid) pc <= pc_inc; else state <= ST_EXEC;
                        OP_OUT: if (out_ready) pc <= pc_inc; else state <= ST_EXEC;
                        OP_CLA, OP_ADD, OP_SUB, OP_SFT: begin
                            acc <= acc_nx;
                            pc  <= pc_inc;
                        end
                        OP_TAC: pc <= acc.neg ? ir_addr : pc_inc;
                        OP_JMP: pc <= ir_addr;
                        OP_HRS: begin
                            pc    <= ir_addr;
                            state <= ST_HALT;
                        end
                        default: pc <= pc_inc;
                    endcase
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    assign in_ready  = in_exec && (op == OP_INP);
    assign out_valid = in_exec && (op == OP_OUT);
    assign out_neg   = ddata.neg;
    assign out_mag   = ddata.mag;
    assign acc_neg   = acc.neg;
    assign acc_mag   = acc.mag;
    assign halted    = (state == ST_HALT);

    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(acc_mag) < ACC_MOD);                                           // R3
    AST_NO_MINUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_neg |-> (acc_mag != '0));                                       // R3
    AST_IO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));                                          // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mag) && $stable(pc))); // R6
    AST_TAC_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (in_exec && op == OP_TAC && !acc_neg) |=> (pc == $past(pc_inc)));   // R7
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (in_exec && op == OP_JMP) |=> (pc == $past(ir_addr)));              // R9
    AST_HALT_STICKS: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && !in_ready && !out_valid));     // R10
endmodule

// File: tb/dcpu_card_cpu_tb_top.sv
module dcpu_card_cpu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_we = 1'b0, ld_neg = 1'b0;
    logic [6:0] ld_addr = '0;
    logic [9:0] ld_mag = '0;
    logic       in_valid, in_ready, in_neg, out_valid, out_neg, halted, acc_neg;
    logic       out_ready = 1'b1;
    logic       in_gate = 1'b1;
    logic [9:0] in_mag, out_mag;
    logic [6:0] pc;
    logic [13:0] acc_mag;

    int n_chk = 0, n_bad = 0;
    int in_n = 0, in_i = 0, out_cnt = 0;
    int in_q [16];
    int out_q [16];

    always #4 clk = ~clk;

    dcpu_card_cpu dut_i (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_neg(ld_neg),
        .ld_mag(ld_mag), .in_valid(in_valid), .in_ready(in_ready), .in_neg(in_neg),
        .in_mag(in_mag), .out_valid(out_valid), .out_ready(out_ready),
        .out_neg(out_neg), .out_mag(out_mag), .pc(pc), .acc_neg(acc_neg),
        .acc_mag(acc_mag), .halted(halted)
    );

    assign in_valid = in_gate && (in_i < in_n);
    assign in_neg   = in_q[in_i & 15] < 0;
    assign in_mag   = 10'(in_q[in_i & 15] < 0 ? -in_q[in_i & 15] : in_q[in_i & 15]);

    always @(posedge clk) begin
        if (rst) begin
            in_i    <= 0;
            out_cnt <= 0;
        end else begin
            if (in_valid && in_ready) in_i <= in_i + 1;
            if (out_valid && out_ready) begin
                out_q[out_cnt & 15] <= out_neg ? -int'(out_mag) : int'(out_mag);
                out_cnt <= out_cnt + 1;
            end
        end
    end

    function automatic int accv();
        return acc_neg ? -int'(acc_mag) : int'(acc_mag);
    endfunction

    function automatic int norm(input int r);
        int m;
        m = (r < 0 ? -r : r) % 10000;
        return (r < 0) ? -m : m;
    endfunction

    function automatic int exp_shift(input int v, input int x, input int y);
        int m;
        m = (v < 0) ? -v : v;
        m = (x >= 4) ? 0 : (m * (10 ** x)) % 10000;
        m = (y >= 4) ? 0 : m / (10 ** y);
        return (v < 0) ? -m : m;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enter_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int v);
        ld_we   = 1'b1;
        ld_addr = 7'(a);
        ld_neg  = v < 0;
        ld_mag  = 10'(v < 0 ? -v : v);
        @(negedge clk);
        ld_we   = 1'b0;
    endtask

    task automatic clr();
        for (int a = 1; a < 100; a++) wr(a, 0);
    endtask

    task automatic go(input string tag);
        int k;
        k = 0;
        ld_we = 1'b0;
        rst   = 1'b0;
        while (!halted && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (!halted) chk({tag, " halt reached"}, 0, 1);
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        enter_reset();
        // R1: reset state
        chk("R1 pc", int'(pc), 10);
        chk("R1 acc", accv(), 0);
        chk("R1 halted", int'(halted), 0);
        chk("R1 in_ready", int'(in_ready), 0);
        chk("R1 out_valid", int'(out_valid), 0);

        // R3 R2: arithmetic sweep, sign on instruction words ignored
        begin
            int vals [7] = '{-999, -500, -1, 0, 1, 499, 999};
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    for (int s = 0; s < 2; s++) begin
                        enter_reset();
                        wr(10, -120);
                        wr(11, (s == 0) ? -221 : 721);
                        wr(12, 933);
                        wr(20, vals[i]);
                        wr(21, vals[j]);
                        go("R3 sweep");
                        chk("R3 add/sub acc", accv(),
                            norm((s == 0) ? vals[i] + vals[j] : vals[i] - vals[j]));
                        chk("R2 halt pc", int'(pc), 33);
                    end
                end
            end
        end

        // R3: magnitude wraps modulo 10000 in both signs
        enter_reset();
        wr(10, 120); wr(11, 410); wr(12, 220); wr(13, 900); wr(20, 999);
        go("R3 wrap+");
        chk("R3 positive wrap", accv(), 989);
        enter_reset();
        wr(10, 120); wr(11, 410); wr(12, 721); wr(13, 900); wr(20, -999); wr(21, 999);
        go("R3 wrap-");
        chk("R3 negative wrap", accv(), -989);

        // R8: shift sweep over all digit pairs
        begin
            int sv [2] = '{987, -605};
            for (int v = 0; v < 2; v++) begin
                for (int x = 0; x < 10; x++) begin
                    for (int y = 0; y < 10; y++) begin
                        enter_reset();
                        wr(10, 120);
                        wr(11, 400 + 10 * x + y);
                        wr(12, 933);
                        wr(20, sv[v]);
                        go("R8 sweep");
                        chk("R8 shift acc", accv(), exp_shift(sv[v], x, y));
                    end
                end
            end
        end

        // R4 R6: store low digits, output with backpressure
        enter_reset();
        clr();
        wr(10, 120); wr(11, 410); wr(12, 630); wr(13, 530); wr(14, 934); wr(20, -123);
        out_ready = 1'b0;
        ld_we = 1'b0;
        rst = 1'b0;
        for (int k = 0; k < 40 && !out_valid; k++) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk("R6 valid held", int'(out_valid), 1);
            chk("R6 data held", out_neg ? -int'(out_mag) : int'(out_mag), -230);
            chk("R6 pc held", int'(pc), 13);
            @(negedge clk);
        end
        out_ready = 1'b1;
        go("R6");
        chk("R6 card count", out_cnt, 1);
        chk("R4 stored low digits", out_q[0], -230);
        chk("R4 acc unchanged", accv(), -1230);
        chk("R4 pc", int'(pc), 34);

        // R5: input waits, cards land in cells
        enter_reset();
        clr();
        in_q[0] = 456; in_q[1] = -7; in_n = 2; in_gate = 1'b0;
        wr(10, 30); wr(11, 31); wr(12, 531); wr(13, 530); wr(14, 131); wr(15, 935);
        ld_we = 1'b0;
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 in_ready while waiting", int'(in_ready), 1);
        chk("R5 pc while waiting", int'(pc), 10);
        in_gate = 1'b1;
        go("R5");
        chk("R5 cards taken", in_i, 2);
        chk("R5 first card out", out_q[0], -7);
        chk("R5 second card out", out_q[1], 456);
        chk("R5 acc", accv(), -7);
        in_n = 0;

        // R7: sign test on negative, zero, positive
        begin
            int tv [3] = '{-5, 0, 5};
            for (int t = 0; t < 3; t++) begin
                enter_reset();
                clr();
                wr(10, 120); wr(11, 340); wr(12, 950); wr(40, 960); wr(20, tv[t]);
                go("R7");
                chk("R7 branch result", int'(pc), (tv[t] < 0) ? 60 : 50);
            end
        end

        // R9: link word in cell 99, return by reaching cell 99, wrap
        enter_reset();
        clr();
        wr(10, 895); wr(11, 599); wr(12, 977);
        wr(95, 599); wr(96, 120); wr(97, 221); wr(98, 630);
        wr(20, 300); wr(21, 45);
        go("R9");
        chk("R9 card count", out_cnt, 2);
        chk("R9 link after jump at 10", out_q[0], 811);
        chk("R9 link after jump at 99", out_q[1], 800);
        chk("R9 final pc", int'(pc), 77);
        chk("R9 subroutine acc", accv(), 345);

        // R10: halt moves pc and stays put with cards on offer
        enter_reset();
        clr();
        in_q[0] = 12; in_n = 1;
        wr(10, 942);
        go("R10");
        chk("R10 pc", int'(pc), 42);
        repeat (20) @(negedge clk);
        chk("R10 still halted", int'(halted), 1);
        chk("R10 pc held", int'(pc), 42);
        chk("R10 no input taken", in_i, 0);
        chk("R10 no output", out_cnt, 0);
        in_n = 0;

        // R11: cell 00 constant
        enter_reset();
        clr();
        wr(0, 555);
        wr(10, 500); wr(11, 120); wr(12, 600); wr(13, 500); wr(14, 100); wr(15, 940);
        wr(20, -321);
        go("R11");
        chk("R11 after loader write", out_q[0], 1);
        chk("R11 after store", out_q[1], 1);
        chk("R11 clear-and-add of cell 00", accv(), 1);

        // R12: two cycles per instruction
        enter_reset();
        clr();
        wr(10, 120); wr(11, 221); wr(12, 940); wr(20, 3); wr(21, 4);
        ld_we = 1'b0;
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 not halted after 5 cycles", int'(halted), 0);
        @(negedge clk);
        chk("R12 halted after 6 cycles", int'(halted), 1);
        chk("R12 acc", accv(), 7);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule